// File: doc/BRIEF.md
# Splitter-Based Record Bucket Partitioner

This block routes a stream of key-value records into a fixed number of buckets whose key ranges do not overlap. Before a run, a set of ascending splitter keys is written into the block. Each record is then classified by itself, by a pipelined binary search over the splitters, and leaves the block with its bucket index attached. No record is ever compared with another record. Inside a bucket, records keep no particular order. Because the classification of one record does not depend on any other, a new record can be taken on every cycle.

The block keeps a running count of the records sent to each bucket. Any bucket that receives more records than a programmable capacity raises a sticky flag, so that software can treat that bucket on its own. A start pulse clears the counts, the flags and the completion indication. The output of one stage can be stored and fed back through a second stage loaded with new splitters, which multiplies the total number of buckets. A record marked as last causes a done indication once it has left the pipeline. From then on the final counts can be read through a select input.

Top module: `bucket_partitioner`

## Requirements
- R1: A write with `spl_we` high stores `spl_key` as splitter number `spl_idx` (0 to B-2). Routing after the write uses the stored value.
- R2: With splitters s0 <= s1 <= ... <= s(B-2), a record's bucket index is the number of splitters less than or equal to its key. A key equal to splitter j therefore goes to bucket j+1, and every key in bucket i is below every key in bucket i+1.
- R3: Key, value and last marker leave the block unchanged, in the order they entered.
- R4: `in_ready` equals `out_ready` in every cycle. While both are high, one record is taken per cycle.
- R5: While `out_ready` is low with `out_valid` high, the output record holds its value. No record is dropped or repeated.
- R6: Each record delivered (`out_valid` and `out_ready` high) adds one to the count of its bucket. `cnt_q` shows the count of bucket `cnt_sel`. Reset and `start` clear all counts.
- R7: Bit b of `ovf` is set by a delivered record whose bucket count already equals `cap`. Once set it stays set until `start` or reset.
- R8: `done` rises in the cycle after a record marked last is delivered. It stays high until `start` or reset.
- R9: After reset, `out_valid`, `done` and `ovf` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears counts, overflow flags and done |
| cap | input | CNT_W | Bucket capacity limit |
| spl_we | input | 1 | Splitter write enable |
| spl_idx | input | BKT_LOG | Splitter number to write |
| spl_key | input | KEY_W | Splitter value |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Input record accepted |
| in_key | input | KEY_W | Input key |
| in_val | input | VAL_W | Input value |
| in_last | input | 1 | Input record is the last of the run |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Downstream can accept |
| out_key | output | KEY_W | Output key |
| out_val | output | VAL_W | Output value |
| out_last | output | 1 | Output record is the last of the run |
| out_bkt | output | BKT_LOG | Bucket index of output record |
| ovf | output | 2**BKT_LOG | Sticky per-bucket overflow flags |
| done | output | 1 | Last record has left |
| cnt_sel | input | BKT_LOG | Bucket whose count is shown |
| cnt_q | output | CNT_W | Count of selected bucket |

## Verification
The case that is hardest to reach from the ports is a bucket crossing its capacity while the pipeline is stalled. Records must reach the overflow threshold with no loss, and the records that arrive after the threshold must leave the flag set. The second run reloads the splitters so that most keys fall into one bucket, and it includes duplicate splitters. It also uses a small capacity and throttles `out_ready` at random, so the flag is set in the middle of stalls and then receives further records. A behavioural model in the bench checks every delivered record, every count and every flag on each clock.

// File: rtl/bucket_partitioner.sv
module bucket_partitioner #(
  parameter int KEY_W   = 16,
  parameter int VAL_W   = 16,
  parameter int BKT_LOG = 3,
  parameter int CNT_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CNT_W-1:0]      cap,
  input  logic                  spl_we,
  input  logic [BKT_LOG-1:0]    spl_idx,
  input  logic [KEY_W-1:0]      spl_key,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [KEY_W-1:0]      in_key,
  input  logic [VAL_W-1:0]      in_val,
  input  logic                  in_last,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [KEY_W-1:0]      out_key,
  output logic [VAL_W-1:0]      out_val,
  output logic                  out_last,
  output logic [BKT_LOG-1:0]    out_bkt,
  output logic [(1<<BKT_LOG)-1:0] ovf,
  output logic                  done,
  input  logic [BKT_LOG-1:0]    cnt_sel,
  output logic [CNT_W-1:0]      cnt_q
);
  localparam int NB   = 1 << BKT_LOG;
  localparam int NSPL = NB - 1;

  logic [KEY_W-1:0] spl [NSPL];
  logic [CNT_W-1:0] cnt [NB];
  logic adv, fire;

  assign adv      = out_ready;
  assign in_ready = out_ready;
  assign fire     = out_valid & out_ready;

  always_ff @(posedge clk)
    if (spl_we && (int'(spl_idx) < NSPL)) spl[spl_idx] <= spl_key;

  for (genvar s = 0; s < BKT_LOG; s++) begin : g_st
    logic             ivld, ilast, rv, rlast;
    logic [KEY_W-1:0] ikey, rkey;
    logic [VAL_W-1:0] ival, rval;
    logic [BKT_LOG-1:0] ipre, cand, rpre;

    if (s == 0) begin : g_first
      assign ivld  = in_valid;
      assign ikey  = in_key;
      assign ival  = in_val;
      assign ilast = in_last;
      assign ipre  = '0;
    end else begin : g_next
      assign ivld  = g_st[s-1].rv;
      assign ikey  = g_st[s-1].rkey;
      assign ival  = g_st[s-1].rval;
      assign ilast = g_st[s-1].rlast;
      assign ipre  = g_st[s-1].rpre;
    end

    assign cand = ipre | BKT_LOG'(1 << (BKT_LOG - 1 - s));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   rv <= 1'b0;
      else if (adv) rv <= ivld;

    always_ff @(posedge clk)
      if (adv) begin
        rkey  <= ikey;
        rval  <= ival;
        rlast <= ilast;
        rpre  <= (ikey >= spl[cand - 1'b1]) ? cand : ipre;
      end
  end

  assign out_valid = g_st[BKT_LOG-1].rv;
  assign out_key   = g_st[BKT_LOG-1].rkey;
  assign out_val   = g_st[BKT_LOG-1].rval;
  assign out_last  = g_st[BKT_LOG-1].rlast;
  assign out_bkt   = g_st[BKT_LOG-1].rpre;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) cnt[i] <= '0;
      ovf  <= '0;
      done <= 1'b0;
    end else if (start) begin
      for (int i = 0; i < NB; i++) cnt[i] <= '0;
      ovf  <= '0;
      done <= 1'b0;
    end else if (fire) begin
      if (cnt[out_bkt] != '1) cnt[out_bkt] <= cnt[out_bkt] + 1'b1;
      if (cnt[out_bkt] == cap) ovf[out_bkt] <= 1'b1;
      if (out_last) done <= 1'b1;
    end

  assign cnt_q = cnt[cnt_sel];

  // R2: the delivered key lies inside the range of its bucket
  a_r2_bucket_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_bkt == '0) || (out_key >= spl[out_bkt - 1'b1])) &&
                  ((out_bkt == BKT_LOG'(NB - 1)) || (out_key < spl[out_bkt])));

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_key) && $stable(out_val) &&
                                  $stable(out_bkt) && $stable(out_last));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((ovf & $past(ovf)) == $past(ovf)));

  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fire && out_last));
endmodule

// File: tb/bucket_partitioner_bench.sv
module bucket_partitioner_bench;
  localparam int KW = 16, VW = 16, BL = 3, CW = 16, NB = 1 << BL;

  logic clk = 0, rst_n = 0, start = 0, spl_we = 0, in_valid = 0, in_last = 0, out_ready = 0;
  logic [CW-1:0] cap = '0;
  logic [BL-1:0] spl_idx = '0, cnt_sel = '0;
  logic [KW-1:0] spl_key = '0, in_key = '0;
  logic [VW-1:0] in_val = '0;
  logic in_ready, out_valid, out_last, done;
  logic [KW-1:0] out_key;
  logic [VW-1:0] out_val;
  logic [BL-1:0] out_bkt;
  logic [NB-1:0] ovf;
  logic [CW-1:0] cnt_q;

  always #4 clk = ~clk;

  bucket_partitioner #(.KEY_W(KW), .VAL_W(VW), .BKT_LOG(BL), .CNT_W(CW)) u_bucket_partitioner (
    .clk, .rst_n, .start, .cap, .spl_we, .spl_idx, .spl_key, .in_valid, .in_ready,
    .in_key, .in_val, .in_last, .out_valid, .out_ready, .out_key, .out_val,
    .out_last, .out_bkt, .ovf, .done, .cnt_sel, .cnt_q);

  typedef struct packed { logic [KW-1:0] k; logic [VW-1:0] v; logic [BL-1:0] b; logic l; } rec_t;
  rec_t q[$];
  int checks = 0, fails = 0, cycles = 0, ready_pct = 100;
  int exp_cnt[NB];
  logic [NB-1:0] exp_ovf = '0;
  logic exp_done = 0;
  logic [KW-1:0] bspl[NB-1];

  function automatic logic [BL-1:0] model_bkt(logic [KW-1:0] k);
    int n = 0;
    for (int j = 0; j < NB - 1; j++) if (bspl[j] <= k) n++;
    return BL'(n);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // monitor and reference model, sampled at the falling edge
  always @(negedge clk) if (rst_n) begin
    rec_t r;
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
    chk("R4 in_ready", in_ready, out_ready);
    chk("R6 count", cnt_q, exp_cnt[cnt_sel]);
    chk("R7 ovf", ovf, exp_ovf);
    chk("R8 done", done, exp_done);
    if (in_valid && in_ready) begin
      r.k = in_key; r.v = in_val; r.l = in_last; r.b = model_bkt(in_key);
      q.push_back(r);
    end
    if (start) begin
      for (int i = 0; i < NB; i++) exp_cnt[i] = 0;
      exp_ovf = '0; exp_done = 0;
    end else if (out_valid && out_ready) begin
      if (q.size() == 0) chk("R5 no extra record", 1, 0);
      else begin
        r = q.pop_front();
        chk("R3 key", out_key, r.k);
        chk("R3 val", out_val, r.v);
        chk("R3 last", out_last, r.l);
        chk("R2 bucket", out_bkt, r.b);
        if (exp_cnt[out_bkt] == int'(cap)) exp_ovf[out_bkt] = 1;
        exp_cnt[out_bkt]++;
        if (out_last) exp_done = 1;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = ($urandom % 100) < ready_pct;
      cnt_sel = cnt_sel + 1'b1;
    end
  end

  task automatic wr_spl(int idx, logic [KW-1:0] val);
    @(posedge clk); #1;
    spl_we = 1; spl_idx = BL'(idx); spl_key = val; bspl[idx] = val;
    @(posedge clk); #1;
    spl_we = 0;
  endtask

  task automatic send(logic [KW-1:0] k, logic [VW-1:0] v, logic l);
    in_valid = 1; in_key = k; in_val = v; in_last = l;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1; start = 1;
    @(posedge clk); #1; start = 0;
  endtask

  task automatic wait_done();
    while (!done) @(posedge clk);
    repeat (2 * NB) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < NB; i++) exp_cnt[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R9 out_valid", out_valid, 0);
    chk("R9 done", done, 0);
    chk("R9 ovf", ovf, 0);

    // run 1: even splitters, boundary keys, mostly ready (R1, R2)
    for (int j = 0; j < NB - 1; j++) wr_spl(j, KW'(100 * (j + 1)));
    cap = 16'd20;
    ready_pct = 90;
    pulse_start();
    send(16'd0, 16'h1, 0);
    send(16'hFFFF, 16'h2, 0);
    send(16'd99, 16'h3, 0);
    for (int j = 1; j < NB; j++) begin
      send(KW'(100 * j), VW'(16'h100 + j), 0);
      send(KW'(100 * j - 1), VW'(16'h200 + j), 0);
    end
    for (int i = 0; i < 40; i++) send(KW'($urandom % 900), VW'(i), i == 39);
    wait_done();
    chk("R8 done after last", done, 1);

    // run 2: duplicate splitters, skew, small capacity, heavy stalls (R5, R7)
    wr_spl(0, 16'd10); wr_spl(1, 16'd20); wr_spl(2, 16'd20); wr_spl(3, 16'd20);
    wr_spl(4, 16'd30); wr_spl(5, 16'd40); wr_spl(6, 16'd50);
    cap = 16'd3;
    ready_pct = 40;
    pulse_start();
    chk("R6 cleared by start", cnt_q, 0);
    chk("R7 cleared by start", ovf, 0);
    send(16'd20, 16'hA0, 0);
    send(16'd19, 16'hA1, 0);
    for (int i = 0; i < 30; i++) send(KW'(20 + ($urandom % 10)), VW'(i), 0);
    for (int i = 0; i < 20; i++) send(KW'($urandom % 64), VW'(i + 50), i == 19);
    wait_done();
    chk("R7 bucket4 overflow", ovf[4], 1);
    chk("R8 done run 2", done, 1);
    summary();
  end
endmodule